// File: doc/BRIEF.md
# Virtual cut-through switch input port

This block is one input port of a packet switch. Packets arrive one word per accepted cycle on a valid/ready link. The first word is a header that names the output port and the total packet length. Payload words follow it, and the last word is a check word. The port reads the header as it is accepted and raises its output request in that same cycle. If the path is granted, each word is passed to the output one cycle after it is accepted.

When the grant does not come, the port keeps taking the packet from the upstream link and writes every word into a local buffer. That buffer holds exactly one packet of the largest legal size. When the grant arrives later, the buffer is read in order, one word per cycle, while the rest of the same packet can still be arriving. Under heavy contention the latency therefore becomes that of store-and-forward, but the upstream link is never held up in the middle of a packet. A new header is accepted only once the previous packet has fully left the port, so packets leave in the order they arrived.

The grant input means the requested output path is free in that cycle. It is only looked at while a request is raised. After a grant, the port owns the path until the packet's last word has been sent.

Top module: `vct_in_port`

## Requirements
- R1: The header word carries the output port number in bits [2:0] and the total packet length in words (header and check word included, legal range 2 to 64) in bits [15:8]. `req_port` shows the header's port number while `req` is high.
- R2: `req` is high in the same cycle the header is accepted. It stays high with a stable `req_port` until a cycle in which `grant` is high.
- R3: If `grant` is high in the cycle the header is accepted and stays high, every word of the packet appears on `out_valid`/`out_data` exactly one cycle after it is accepted.
- R4: Once a header has been accepted, `in_ready` stays high until the packet's last word is accepted. This holds whatever the grant does. While no grant has been seen, `out_valid` stays low.
- R5: After a late grant, the buffered words are sent one per cycle, oldest first, while the remaining words of the same packet are still being accepted. The output never runs ahead of the input.
- R6: Between packets, `in_ready` is low while the buffer holds any word or the previous packet has not finished leaving. It returns high once both conditions clear.
- R7: Every word leaves unchanged and in arrival order, and packets leave in arrival order.
- R8: During and right after reset, `in_ready` is 1, `out_valid` is 0 and `req` is 0.
- R9: The buffer holds 64 words, the largest legal packet. A maximum-length packet that is never granted is absorbed entirely without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Port accepts the upstream word |
| in_data | input | 16 | Upstream word |
| req | output | 1 | Request for an output path |
| req_port | output | 3 | Output port being requested |
| grant | input | 1 | Requested path is free this cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output word |

## Verification
The hardest case to reach is a grant that arrives in the middle of a packet. At that moment the buffer is being drained and written in the same cycles, and the read side must catch up with the write side and then switch to direct pass-through without dropping or repeating a word. A directed test holds the grant low for the first dozen words of a 30-word packet and then raises it. A randomized-grant phase with gaps in the upstream traffic then hits the same crossover at many different offsets, while a scoreboard checks every word and its order.

// File: rtl/vct_pkg.sv
package vct_pkg;
  localparam int DATA_W       = 16;
  localparam int PORT_W       = 3;
  localparam int LEN_W        = 8;
  localparam int HDR_PORT_LSB = 0;
  localparam int HDR_LEN_LSB  = 8;

  typedef logic [DATA_W-1:0] word_t;

  function automatic logic [PORT_W-1:0] hdr_port(input word_t w);
    return w[HDR_PORT_LSB +: PORT_W];
  endfunction

  function automatic logic [LEN_W-1:0] hdr_len(input word_t w);
    return w[HDR_LEN_LSB +: LEN_W];
  endfunction
endpackage

// File: rtl/vct_rx_track.sv
module vct_rx_track
  import vct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  input  logic [LEN_W-1:0] len,
  output logic             busy
);
  logic [LEN_W-1:0] rem_q, rem_d;

  assign busy = (rem_q != '0);

  always_comb begin
    rem_d = rem_q;
    if (in_fire) begin
      if (!busy) rem_d = len - LEN_W'(1);
      else       rem_d = rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end
endmodule

// File: rtl/vct_store.sv
module vct_store
  import vct_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  word_t                    wr_data,
  input  logic                     rd_en,
  output word_t                    rd_data,
  output logic [$clog2(DEPTH):0]   cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  word_t           mem [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [AW:0]     cnt_q, cnt_d;

  assign rd_data = mem[rd_ptr_q];
  assign cnt     = cnt_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (rd_en) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end
endmodule

// File: rtl/vct_path_ctrl.sv
module vct_path_ctrl
  import vct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_fire,
  input  logic [PORT_W-1:0] hdr_port_i,
  input  logic [LEN_W-1:0]  hdr_len_i,
  input  logic              in_fire,
  input  logic              buf_nonempty,
  input  logic              grant,
  output logic              req,
  output logic [PORT_W-1:0] req_port,
  output logic              from_buf,
  output logic              bypass,
  output logic              active
);
  logic              pend_q, pend_d, gnt_q, gnt_d, go, emit;
  logic [PORT_W-1:0] port_q, port_d;
  logic [LEN_W-1:0]  rem_q, rem_d, rem_cur;

  assign req      = hdr_fire | pend_q;
  assign req_port = hdr_fire ? hdr_port_i : port_q;
  assign go       = gnt_q | (req & grant);
  assign from_buf = go & buf_nonempty;
  assign bypass   = go & ~buf_nonempty & in_fire;
  assign emit     = from_buf | bypass;
  assign active   = pend_q | gnt_q;
  assign rem_cur  = hdr_fire ? hdr_len_i : rem_q;

  always_comb begin
    rem_d  = emit ? rem_cur - LEN_W'(1) : rem_cur;
    port_d = hdr_fire ? hdr_port_i : port_q;
    pend_d = pend_q;
    if (hdr_fire)              pend_d = ~grant;
    else if (pend_q && grant)  pend_d = 1'b0;
    gnt_d = gnt_q;
    if (req && grant)                      gnt_d = 1'b1;
    if (emit && rem_cur == LEN_W'(1))      gnt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      gnt_q  <= 1'b0;
      port_q <= '0;
      rem_q  <= '0;
    end else begin
      pend_q <= pend_d;
      gnt_q  <= gnt_d;
      port_q <= port_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/vct_in_port.sv
module vct_in_port
  import vct_pkg::*;
#(
  parameter int MAX_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              req,
  output logic [PORT_W-1:0] req_port,
  input  logic              grant,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int CW = $clog2(MAX_WORDS) + 1;

  logic          rst_s1_q, rst_s2_q;
  logic          in_fire, hdr_fire, rx_busy, active;
  logic          from_buf, bypass, emit, wr_en;
  logic [CW-1:0] buf_cnt;
  word_t         rd_data;
  logic          out_valid_q;
  word_t         out_data_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign in_ready = rx_busy | (~active & (buf_cnt == '0));
  assign in_fire  = in_valid & in_ready;
  assign hdr_fire = in_fire & ~rx_busy;
  assign emit     = from_buf | bypass;
  assign wr_en    = in_fire & ~bypass;

  vct_rx_track u_rx (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .in_fire (in_fire),
    .len     (hdr_len(in_data)),
    .busy    (rx_busy)
  );

  vct_store #(.DEPTH(MAX_WORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .wr_en   (wr_en),
    .wr_data (in_data),
    .rd_en   (from_buf),
    .rd_data (rd_data),
    .cnt     (buf_cnt)
  );

  vct_path_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_s2_q),
    .hdr_fire     (hdr_fire),
    .hdr_port_i   (hdr_port(in_data)),
    .hdr_len_i    (hdr_len(in_data)),
    .in_fire      (in_fire),
    .buf_nonempty (buf_cnt != '0),
    .grant        (grant),
    .req          (req),
    .req_port     (req_port),
    .from_buf     (from_buf),
    .bypass       (bypass),
    .active       (active)
  );

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) out_valid_q <= 1'b0;
    else           out_valid_q <= emit;
  end

  always_ff @(posedge clk) begin
    if (emit) out_data_q <= from_buf ? rd_data : in_data;
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/vct_in_port_chk.sv
module vct_in_port_chk
  import vct_pkg::*;
#(
  parameter int MAX_WORDS = 64,
  parameter int CW        = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              req,
  input logic [PORT_W-1:0] req_port,
  input logic              grant,
  input logic              out_valid,
  input logic [CW-1:0]     buf_cnt
);
  logic [LEN_W-1:0] rem_q;
  logic [31:0]      n_in_q, n_out_q;
  logic             acc;

  assign acc = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      n_in_q  <= '0;
      n_out_q <= '0;
    end else begin
      if (acc) rem_q <= (rem_q == '0) ? hdr_len(in_data) - LEN_W'(1) : rem_q - LEN_W'(1);
      n_in_q  <= n_in_q + 32'(acc);
      n_out_q <= n_out_q + 32'(out_valid);
    end
  end

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q != '0 |-> in_ready);  // R4
  AST_HDR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc && rem_q == '0 |-> req && req_port == hdr_port(in_data));  // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req && !grant |=> req && req_port == $past(req_port));  // R2
  AST_OUT_BEHIND_IN: assert property (@(posedge clk) disable iff (!rst_n)
    n_out_q <= n_in_q);  // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(buf_cnt) <= MAX_WORDS);  // R9
endmodule

bind vct_in_port vct_in_port_chk #(.MAX_WORDS(MAX_WORDS), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .req       (req),
  .req_port  (req_port),
  .grant     (grant),
  .out_valid (out_valid),
  .buf_cnt   (buf_cnt)
);

// File: tb/test_vct_in_port.sv
module test_vct_in_port;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_valid, in_ready, req, grant, out_valid;
  logic [15:0] in_data, out_data;
  logic [2:0]  req_port;

  int n_tests, n_fail, cyc, gmode, lat_mode, blocked;
  logic [15:0] exp_q[$];
  int          acc_q[$];

  vct_in_port i_vct_in_port (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .req(req), .req_port(req_port), .grant(grant),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // grant driver: 0 = withheld, 1 = held, 2 = random
  always @(negedge clk) begin
    if (gmode == 0)      grant = 1'b0;
    else if (gmode == 1) grant = 1'b1;
    else                 grant = ($urandom % 3) == 0;
  end

  // scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (blocked != 0) check(1'b0, "R4 output while ungranted", 1, 0);
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected word", int'(out_data), -1);
      else begin
        logic [15:0] e; int a;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        check(out_data == e, "R7 word content/order", int'(out_data), int'(e));
        if (lat_mode != 0) check(cyc == a + 1, "R3 pass-through latency", cyc - a, 1);
      end
    end
  end

  task automatic send_pkt(input logic [2:0] port, input int len, input int gap_pct);
    logic [15:0] chk;
    chk = '0;
    for (int i = 0; i < len; i++) begin
      logic [15:0] w;
      if (i == 0)            w = {8'(len), 5'b0, port};
      else if (i == len - 1) w = chk;
      else                   w = 16'($urandom);
      chk = chk ^ w;
      @(negedge clk);
      while (i > 0 && int'($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = w;
      #1;
      if (i == 0) begin
        while (!in_ready) begin @(negedge clk); #1; end
        check(req == 1'b1, "R2 req with header", int'(req), 1);
        check(req_port == port, "R1 req_port from header", int'(req_port), int'(port));
      end else begin
        check(in_ready == 1'b1, "R4 ready held mid-packet", int'(in_ready), 1);
        while (!in_ready) begin @(negedge clk); #1; end
      end
      exp_q.push_back(w);
      acc_q.push_back(cyc);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int n;
    n = 0;
    while ((exp_q.size() != 0 || !in_ready) && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0 && in_ready, tag, exp_q.size(), 0);
  endtask

  task automatic t_reset();
    #1;
    check(in_ready == 1'b1, "R8 in_ready at reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8 out_valid at reset", int'(out_valid), 0);
    check(req == 1'b0, "R8 req at reset", int'(req), 0);
  endtask

  task automatic t_cut_through();
    gmode = 1; lat_mode = 1;
    send_pkt(3'd5, 5, 0);
    send_pkt(3'd2, 2, 0);
    wait_drain("R3 cut-through drained");
    lat_mode = 0;
  endtask

  task automatic t_blocked_max();
    gmode = 0; blocked = 1;
    send_pkt(3'd7, 64, 0);
    #1;
    check(in_ready == 1'b0, "R6 ready low with buffered packet", int'(in_ready), 0);
    check(req == 1'b1 && req_port == 3'd7, "R2 request held", int'(req), 1);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 64, "R9 full packet absorbed", exp_q.size(), 64);
    blocked = 0;
    gmode = 1;
    wait_drain("R9 max packet drained");
  endtask

  task automatic t_late_grant();
    gmode = 0; blocked = 1;
    fork
      send_pkt(3'd1, 30, 0);
      begin
        repeat (12) @(negedge clk);
        blocked = 0;
        gmode = 1;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b1 && in_valid == 1'b1, "R5 drain overlaps arrival",
              int'(out_valid), 1);
      end
    join
    wait_drain("R5 late-grant packet drained");
  endtask

  task automatic t_random();
    gmode = 2;
    for (int p = 0; p < 10; p++) send_pkt(3'($urandom), 2 + int'($urandom % 63), 20);
    gmode = 1;
    wait_drain("R7 random traffic drained");
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0; gmode = 0; lat_mode = 0; blocked = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cut_through();
    t_blocked_max();
    t_late_grant();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule